// File: doc/BRIEF.md
# Multi-Mode Iterative Sequential Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor, one quotient bit per clock, and returns a 16-bit quotient and a 16-bit remainder on two separate result ports. A 3-bit mode code selects the operation: unsigned or signed integer division with a one-word or two-word dividend, or signed Q15 fractional division. Whatever the mode, the datapath is the same. The operands are converted to magnitudes at start, sixteen compare-subtract steps produce the quotient, and two more steps apply the signs.

The block does not count its own iterations. A surrounding loop controller supplies a step enable and a down-counting iteration index, and the block uses that index to choose its action. One start cycle and eighteen step cycles, with the index running from 17 down to 0, make up a complete divide of nineteen cycles. The controller may stall between steps. The full working state is available on a context output and can be written back through a context input, so an interrupt handler can save the operation, use the divider for something else, and resume it later.

The controller moves through three states:
- ST_IDLE goes to ST_SHIFT on start.
- ST_SHIFT stays where it is for each step with an index of 2 or more. It goes to ST_FIXREM on the step with index 1, which applies the quotient sign.
- ST_FIXREM goes to ST_IDLE on the step with index 0, which applies the remainder sign and raises done.
- From any state, start goes to ST_SHIFT, and a context load goes to the saved state.

Top module: `iter_divider`

## Requirements
- R1: Mode code 0 divides `dividend_lo`, zero-extended to 32 bits, by `divisor` as unsigned values. Codes 5, 6 and 7 behave exactly like code 0.
- R2: Mode code 1 sign-extends `dividend_lo` and divides it by the signed `divisor`. The quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R3: Mode code 2 divides the unsigned 32-bit value {`dividend_hi`, `dividend_lo`} by the unsigned `divisor`.
- R4: Mode code 3 divides the signed 32-bit value {`dividend_hi`, `dividend_lo`} by the signed `divisor`, with the same sign rules as R2.
- R5: Mode code 4 treats `dividend_lo` and `divisor` as signed Q15 values. The quotient is the signed value dividend_lo·2^15/divisor truncated toward zero, and the remainder is that division's remainder.
- R6: After the start cycle, the block needs 18 cycles with `step_en` high and `step_cnt` running 17 down to 0. `done` is high for exactly the one cycle after the cycle that carried index 0. From that cycle until the next start, `quotient` and `remainder` hold the result.
- R7: A cycle with `step_en` low does not change the results or the context. Stalls of any length between steps leave the final result unchanged.
- R8: `ctx_out` carries the complete working state. One cycle with `ctx_load` high and `start` low makes `ctx_out` equal to `ctx_in`. Resuming the remaining steps after such a restore gives the same result as an uninterrupted divide. Start takes priority over a context load.
- R9: A zero divisor at start raises `div_zero` in the next cycle, and it stays high until the next start. A nonzero divisor at start clears it. In this case the quotient and remainder are unspecified.
- R10: A start during a divide abandons that divide and begins the new one. `busy` is high and `done` is low in the cycle after any start.
- R11: After reset, `quotient`, `remainder`, `done`, `busy` and `div_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin a divide |
| mode | input | 3 | Operation select (codes in R1 to R5) |
| dividend_hi | input | 16 | Upper dividend word (two-word modes) |
| dividend_lo | input | 16 | Lower or only dividend word |
| divisor | input | 16 | Divisor |
| step_en | input | 1 | Loop controller is issuing a step this cycle |
| step_cnt | input | 5 | Iteration index from the loop controller, 17 down to 0 |
| ctx_load | input | 1 | Restore working state from ctx_in |
| ctx_in | input | 53 | Saved working state |
| ctx_out | output | 53 | Current working state |
| quotient | output | 16 | Quotient (primary result) |
| remainder | output | 16 | Remainder (secondary result) |
| done | output | 1 | One-cycle pulse: results valid |
| busy | output | 1 | A divide is in progress |
| div_zero | output | 1 | Divisor was zero at the last start |

## Verification
The quotient and remainder are due one cycle after the register edge that takes index 0, which is nineteen edges after start when the loop does not stall. The bench drives on falling edges and checks `done`, both results and `busy` at the falling edge right after that last step. It then checks that `done` has fallen one cycle later. `div_zero` and `busy` are due one edge after start and are sampled at the falling edge that follows it. A restored context is compared one edge after the load. During stalls the results are expected to stay frozen, so the expected values never move with the stall length.

// File: rtl/itdiv_pkg.sv
package itdiv_pkg;
    localparam int DW      = 16;
    localparam int NSTEP   = DW + 2;
    localparam int CW      = $clog2(NSTEP);

    typedef enum logic [2:0] {
        M_U16  = 3'd0,
        M_S16  = 3'd1,
        M_U32  = 3'd2,
        M_S32  = 3'd3,
        M_FRAC = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FIXREM = 2'd2
    } state_e;

    typedef struct packed {
        state_e          st;
        logic [DW-1:0]   prem;
        logic [DW-1:0]   pquo;
        logic [DW-1:0]   dmag;
        logic            qneg;
        logic            rneg;
        logic            dz;
    } ctx_t;

    localparam int CTX_W = $bits(ctx_t);
endpackage

// File: rtl/itdiv_prep.sv
module itdiv_prep
    import itdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   mode,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dv,
    output logic [W-1:0] nmag_hi,
    output logic [W-1:0] nmag_lo,
    output logic [W-1:0] dmag,
    output logic         n_neg,
    output logic         d_neg,
    output logic         d_zero
);
    localparam int NW = 2 * W;

    logic          signed_op;
    logic [NW-1:0] num;
    logic [NW-1:0] num_abs;

    // Dividend framing per mode; unknown codes fall back to one-word unsigned
    always_comb begin
        signed_op = 1'b0;
        num       = {{W{1'b0}}, lo};
        unique case (mode)
            M_U16: begin
                signed_op = 1'b0;
                num       = {{W{1'b0}}, lo};
            end
            M_S16: begin
                signed_op = 1'b1;
                num       = {{W{lo[W-1]}}, lo};
            end
            M_U32: begin
                signed_op = 1'b0;
                num       = {hi, lo};
            end
            M_S32: begin
                signed_op = 1'b1;
                num       = {hi, lo};
            end
            M_FRAC: begin
                signed_op = 1'b1;
                num       = {lo[W-1], lo, {(W-1){1'b0}}};
            end
            default: begin
                signed_op = 1'b0;
                num       = {{W{1'b0}}, lo};
            end
        endcase
    end

    assign n_neg   = signed_op & num[NW-1];
    assign d_neg   = signed_op & dv[W-1];
    assign num_abs = n_neg ? (~num + NW'(1)) : num;
    assign nmag_hi = num_abs[NW-1:W];
    assign nmag_lo = num_abs[W-1:0];
    assign dmag    = d_neg ? (~dv + W'(1)) : dv;
    assign d_zero  = (dv == '0);
endmodule

// File: rtl/itdiv_step.sv
module itdiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] prem,
    input  logic [W-1:0] pquo,
    input  logic [W-1:0] dmag,
    output logic [W-1:0] prem_nx,
    output logic [W-1:0] pquo_nx
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    // One restoring step: bring in the next dividend bit, subtract if it fits
    always_comb begin
        trial   = {prem, pquo[W-1]};
        diff    = trial - {1'b0, dmag};
        fits    = (trial >= {1'b0, dmag});
        prem_nx = fits ? diff[W-1:0] : trial[W-1:0];
        pquo_nx = {pquo[W-2:0], fits};
    end
endmodule

// File: rtl/itdiv_sign.sv
module itdiv_sign #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         neg,
    output logic [W-1:0] res
);
    assign res = neg ? (~val + W'(1)) : val;
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import itdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [DW-1:0]    dividend_hi,
    input  logic [DW-1:0]    dividend_lo,
    input  logic [DW-1:0]    divisor,
    input  logic             step_en,
    input  logic [CW-1:0]    step_cnt,
    input  logic             ctx_load,
    input  logic [CTX_W-1:0] ctx_in,
    output logic [CTX_W-1:0] ctx_out,
    output logic [DW-1:0]    quotient,
    output logic [DW-1:0]    remainder,
    output logic             done,
    output logic             busy,
    output logic             div_zero
);
    localparam logic [CW-1:0] CNT_Q = CW'(1);
    localparam logic [CW-1:0] CNT_R = CW'(0);

    state_e        st, st_nx;
    logic [DW-1:0] prem, pquo, dmag;
    logic          qneg, rneg, dz;
    logic          do_shift, do_fixq, do_fixr;
    ctx_t          ld;

    logic [DW-1:0] p_nhi, p_nlo, p_dmag;
    logic          p_nneg, p_dneg, p_dz;
    logic [DW-1:0] s_prem, s_pquo;
    logic [DW-1:0] q_signed, r_signed;

    assign ld = ctx_t'(ctx_in);

    itdiv_prep #(.W(DW)) u_prep (
        .mode    (mode),
        .hi      (dividend_hi),
        .lo      (dividend_lo),
        .dv      (divisor),
        .nmag_hi (p_nhi),
        .nmag_lo (p_nlo),
        .dmag    (p_dmag),
        .n_neg   (p_nneg),
        .d_neg   (p_dneg),
        .d_zero  (p_dz)
    );

    itdiv_step #(.W(DW)) u_step (
        .prem    (prem),
        .pquo    (pquo),
        .dmag    (dmag),
        .prem_nx (s_prem),
        .pquo_nx (s_pquo)
    );

    itdiv_sign #(.W(DW)) u_qsign (
        .val (pquo),
        .neg (qneg),
        .res (q_signed)
    );

    itdiv_sign #(.W(DW)) u_rsign (
        .val (prem),
        .neg (rneg),
        .res (r_signed)
    );

    // Next state and step decode from the external iteration index
    always_comb begin
        st_nx    = st;
        do_shift = 1'b0;
        do_fixq  = 1'b0;
        do_fixr  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                st_nx = ST_IDLE;
            end
            ST_SHIFT: begin
                if (step_en) begin
                    if (step_cnt > CNT_Q) begin
                        do_shift = 1'b1;
                    end else if (step_cnt == CNT_Q) begin
                        do_fixq = 1'b1;
                        st_nx   = ST_FIXREM;
                    end
                end
            end
            ST_FIXREM: begin
                if (step_en && step_cnt == CNT_R) begin
                    do_fixr = 1'b1;
                    st_nx   = ST_IDLE;
                end
            end
            default: begin
                st_nx = ST_IDLE;
            end
        endcase
        if (start) begin
            st_nx = ST_SHIFT;
        end else if (ctx_load) begin
            st_nx = ld.st;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Working registers: partial remainder, quotient shifter, divisor magnitude, signs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prem <= '0;
            pquo <= '0;
            dmag <= '0;
            qneg <= 1'b0;
            rneg <= 1'b0;
            dz   <= 1'b0;
        end else if (start) begin
            prem <= p_nhi;
            pquo <= p_nlo;
            dmag <= p_dmag;
            qneg <= p_nneg ^ p_dneg;
            rneg <= p_nneg;
            dz   <= p_dz;
        end else if (ctx_load) begin
            prem <= ld.prem;
            pquo <= ld.pquo;
            dmag <= ld.dmag;
            qneg <= ld.qneg;
            rneg <= ld.rneg;
            dz   <= ld.dz;
        end else if (do_shift) begin
            prem <= s_prem;
            pquo <= s_pquo;
        end else if (do_fixq) begin
            pquo <= q_signed;
        end else if (do_fixr) begin
            prem <= r_signed;
        end
    end

    // Output process: completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= do_fixr && !start && !ctx_load;
        end
    end

    assign quotient  = pquo;
    assign remainder = prem;
    assign busy      = (st != ST_IDLE);
    assign div_zero  = dz;
    assign ctx_out   = {st, prem, pquo, dmag, qneg, rneg, dz};

    // R6: completion is a single-cycle pulse and the controller is idle then
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: a stalled step leaves results and context untouched
    p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_en && !start && !ctx_load)
        |=> ($stable(quotient) && $stable(remainder) && $stable(ctx_out)));
    // R8: a context load reproduces the saved state exactly
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load && !start && ctx_in[CTX_W-1 -: 2] != 2'b11)
        |=> (ctx_out == $past(ctx_in)));
    // R9: divide-by-zero flag only changes on start or restore
    p_dz_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !ctx_load) |=> $stable(div_zero));
    // R10: start always (re)enters the iterating state
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));
endmodule

// File: tb/iter_divider_bench.sv
module iter_divider_bench;
    import itdiv_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       mode = '0;
    logic [15:0]      dividend_hi = '0;
    logic [15:0]      dividend_lo = '0;
    logic [15:0]      divisor = '0;
    logic             step_en = 1'b0;
    logic [CW-1:0]    step_cnt = '0;
    logic             ctx_load = 1'b0;
    logic [CTX_W-1:0] ctx_in = '0;
    logic [CTX_W-1:0] ctx_out;
    logic [15:0]      quotient, remainder;
    logic             done, busy, div_zero;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    iter_divider u_iter_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .step_en     (step_en),
        .step_cnt    (step_cnt),
        .ctx_load    (ctx_load),
        .ctx_in      (ctx_in),
        .ctx_out     (ctx_out),
        .quotient    (quotient),
        .remainder   (remainder),
        .done        (done),
        .busy        (busy),
        .div_zero    (div_zero)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [2:0] m);
        case (m)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R1";
        endcase
    endfunction

    // Reference model from the requirements; ok = quotient fits and divisor nonzero
    function automatic void ref_div(input logic [2:0] m, input logic [15:0] hi,
                                    input logic [15:0] lo, input logic [15:0] d,
                                    output logic [15:0] q, output logic [15:0] r,
                                    output bit ok);
        longint n, dd, qq, rr;
        bit sgn;
        sgn = 1'b1;
        case (m)
            3'd1: begin n = longint'($signed(lo)); dd = longint'($signed(d)); end
            3'd2: begin n = {32'h0, hi, lo}; dd = {48'h0, d}; sgn = 1'b0; end
            3'd3: begin n = longint'($signed({hi, lo})); dd = longint'($signed(d)); end
            3'd4: begin n = longint'($signed(lo)) * 32768; dd = longint'($signed(d)); end
            default: begin n = {48'h0, lo}; dd = {48'h0, d}; sgn = 1'b0; end
        endcase
        ok = (dd != 0);
        qq = 0;
        rr = 0;
        if (ok) begin
            qq = n / dd;
            rr = n % dd;
            if (sgn) ok = (qq >= -32768) && (qq <= 32767);
            else     ok = (qq <= 65535);
        end
        q = qq[15:0];
        r = rr[15:0];
    endfunction

    task automatic issue_start(input logic [2:0] m, input logic [15:0] hi,
                               input logic [15:0] lo, input logic [15:0] d);
        @(negedge clk);
        start = 1'b1;
        mode = m;
        dividend_hi = hi;
        dividend_lo = lo;
        divisor = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_steps(input int first, input int last, input bit gaps);
        for (int c = first; c >= last; c--) begin
            step_en = 1'b1;
            step_cnt = CW'(c);
            @(negedge clk);
            if (gaps && c > 0 && $urandom_range(0, 2) == 0) begin
                step_en = 1'b0;
                repeat ($urandom_range(1, 4)) @(negedge clk);
            end
        end
        step_en = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [15:0] q,
                                input logic [15:0] r);
        check("R6", "done", done, 1);
        check("R6", "busy at done", busy, 0);
        check(req, "quotient", quotient, q);
        check(req, "remainder", remainder, r);
        @(negedge clk);
        check("R6", "done falls", done, 0);
    endtask

    task automatic run_case(input logic [2:0] m, input logic [15:0] hi,
                            input logic [15:0] lo, input logic [15:0] d,
                            input bit gaps);
        logic [15:0] q, r;
        bit ok;
        ref_div(m, hi, lo, d, q, r, ok);
        issue_start(m, hi, lo, d);
        check("R10", "busy after start", busy, 1);
        do_steps(17, 0, gaps);
        check_result(gaps ? "R7" : mode_req(m), q, r);
    endtask

    task automatic pick(output logic [2:0] m, output logic [15:0] hi,
                        output logic [15:0] lo, output logic [15:0] d);
        logic [15:0] q, r;
        bit ok;
        ok = 1'b0;
        m = '0; hi = '0; lo = '0; d = 16'd1;
        while (!ok) begin
            m  = 3'($urandom_range(0, 7));
            hi = 16'($urandom);
            lo = 16'($urandom);
            d  = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(1, 9)) : 16'($urandom);
            ref_div(m, hi, lo, d, q, r, ok);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]       m;
        logic [15:0]      hi, lo, d, q, r;
        logic [CTX_W-1:0] saved;
        bit               ok;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11", "quotient", quotient, 0);
        check("R11", "remainder", remainder, 0);
        check("R11", "done", done, 0);
        check("R11", "busy", busy, 0);
        check("R11", "div_zero", div_zero, 0);
        rst_n = 1'b1;

        // Directed corners
        run_case(3'd0, 16'h0000, 16'hFFFF, 16'h0001, 1'b0);    // R1 max / 1
        run_case(3'd6, 16'hABCD, 16'd1000, 16'd7, 1'b0);       // R1 code 6, hi ignored
        run_case(3'd1, 16'h0000, 16'h8000, 16'h0001, 1'b0);    // R2 most negative
        run_case(3'd1, 16'h1234, 16'hFFF9, 16'h0002, 1'b0);    // R2 -7/2
        run_case(3'd2, 16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0);    // R3 largest quotient
        run_case(3'd3, 16'hFFFE, 16'h7960, 16'h0007, 1'b0);    // R4 -100000/7
        run_case(3'd3, 16'h0001, 16'h86A0, 16'hFFF9, 1'b0);    // R4 100000/-7
        run_case(3'd4, 16'h0000, 16'h2000, 16'h4000, 1'b0);    // R5 0.25/0.5
        run_case(3'd4, 16'h0000, 16'hE000, 16'h4000, 1'b0);    // R5 -0.25/0.5

        // R9: divide by zero flag set and held
        issue_start(3'd0, 16'h0, 16'd55, 16'h0);
        check("R9", "div_zero set", div_zero, 1);
        do_steps(17, 0, 1'b0);
        check("R9", "div_zero held", div_zero, 1);
        check("R6", "done after zero divide", done, 1);
        issue_start(3'd0, 16'h0, 16'd55, 16'd5);
        check("R9", "div_zero cleared", div_zero, 0);
        do_steps(17, 0, 1'b0);
        check_result("R1", 16'd11, 16'd0);

        // R10: restart mid-operation
        issue_start(3'd2, 16'h0003, 16'h1111, 16'h0100);
        do_steps(17, 9, 1'b0);
        ref_div(3'd1, 16'h0, 16'hF000, 16'd3, q, r, ok);
        issue_start(3'd1, 16'h0, 16'hF000, 16'd3);
        check("R10", "busy after restart", busy, 1);
        do_steps(17, 0, 1'b0);
        check_result("R10", q, r);

        // R8: save mid-operation, run another divide, restore and resume
        for (int k = 0; k < 6; k++) begin
            int cut;
            logic [2:0]  m2;
            logic [15:0] hi2, lo2, d2;
            pick(m, hi, lo, d);
            ref_div(m, hi, lo, d, q, r, ok);
            cut = $urandom_range(1, 17);
            issue_start(m, hi, lo, d);
            do_steps(17, cut, 1'b0);
            saved = ctx_out;
            pick(m2, hi2, lo2, d2);
            run_case(m2, hi2, lo2, d2, 1'b0);
            ctx_in = saved;
            ctx_load = 1'b1;
            @(negedge clk);
            ctx_load = 1'b0;
            check("R8", "restored context", ctx_out, saved);
            do_steps(cut - 1, 0, 1'b0);
            check_result("R8", q, r);
        end

        // Constrained random, some with stalls (R7)
        for (int i = 0; i < 150; i++) begin
            pick(m, hi, lo, d);
            run_case(m, hi, lo, d, (i % 3) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule